// File: doc/BRIEF.md
# Gated-Timer Asynchronous Serial Receiver

This block receives 8-bit asynchronous characters framed with one start bit, eight data bits sent least significant bit first, and one stop bit. Its bit timer does not run while the line is idle. The timer stays cleared until the synchronized line falls, which marks a possible start bit. From that edge it produces ticks at two or three times the bit rate. A divisor input sets how many system clocks make one tick. The divisor and the oversample mode are both taken at the start edge, so a receiver can run at a rate that has nothing to do with any transmitter on the same chip.

In the double-rate mode, every other tick lands in the middle of a bit and the receiver samples there. In the triple-rate mode, each bit is cut into thirds. The two thirds that surround a bit boundary form the transition zone, where the line may move. The middle third is the stable zone. If the line changes anywhere inside a stable zone, the receiver reports a glitch. A start bit that is no longer low at the first tick is treated as noise and dropped. A low stop bit is reported as a framing error, and the byte is still handed over.

Top module: `uart_gt_rx`

## Requirements
- R1: While no frame is in progress, the tick divider stays at zero. A line held high produces no output pulse, however long it stays high.
- R2: A frame begins on a high-to-low change of the synchronized line. The mode (0 = double rate, 1 = triple rate) and the divisor are captured at that edge. Changes to either input later in the frame have no effect on that frame. A divisor of 0 is treated as 1.
- R3: Tick k falls k×D system clocks after the start edge is seen, where D is the captured divisor. In double-rate mode the start bit is checked at tick 1, data bit i (i = 0..7) is sampled at tick 2i+3, and the stop bit is sampled at tick 19.
- R4: If the line is high at tick 1, the frame is abandoned with no output pulse and the receiver returns to idle. It then accepts the next start edge normally.
- R5: In triple-rate mode, bit j (0 = start, 1..8 = data, 9 = stop) is sampled at tick 3j+1. Its stable zone runs from tick 3j+1 to tick 3j+2 inclusive. Any change of the line inside a stable zone sets the glitch error, and the byte is still delivered. Changes in transition zones are ignored. Double-rate mode never reports a glitch.
- R6: A stop bit sampled low sets the framing error. valid_o still pulses and data_o carries the received byte.
- R7: valid_o, frame_err_o and glitch_err_o pulse together for exactly one cycle. The pulse comes 3 + 19×D clocks (double rate) or 3 + 29×D clocks (triple rate) after the cycle in which rx_i first goes low. data_o holds the last byte until the next delivery.
- R8: After a frame completes, the receiver waits for a new falling edge. A line that stays low after a low stop bit starts no further frame until it has gone high and then fallen again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| mode_i | input | 1 | Oversample select: 0 = double rate, 1 = triple rate |
| div_i | input | DIV_W | System clocks per tick (0 is treated as 1) |
| data_o | output | 8 | Last received byte |
| valid_o | output | 1 | One-cycle pulse when a byte is delivered |
| frame_err_o | output | 1 | Pulses with valid_o when the stop bit was low |
| glitch_err_o | output | 1 | Pulses with valid_o when the line moved inside a stable zone |

## Verification
The embedded properties assume three things about the inputs. The divisor is never loaded in the middle of a frame. The shortest frame spans at least twenty ticks, so two delivery pulses can never touch. The stable-zone window opens only in triple-rate mode.

The stimulus keeps within these limits. It always drives characters with the nominal bit period that matches the captured mode and divisor. It changes mode and divisor only after the start edge has been captured. Every glitch it injects lasts one clock and is placed either in the middle of a stable zone or one clock past a bit boundary, so each injected glitch falls clearly inside one zone.

// File: rtl/uart_gt_pkg.sv
package uart_gt_pkg;

    typedef enum logic {
        OVS_2X = 1'b0,
        OVS_3X = 1'b1
    } ovs_mode_e;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_BUSY = 1'b1
    } rx_state_e;

    localparam int DATA_BITS  = 8;
    localparam int FRAME_BITS = DATA_BITS + 2;
    localparam int STOP_IDX   = DATA_BITS + 1;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 valid;
        logic                 frame_err;
        logic                 glitch_err;
    } rx_result_t;

    // Number of ticks in one bit period for the given mode.
    function automatic logic [1:0] ovs_factor(ovs_mode_e m);
        return (m == OVS_3X) ? 2'd3 : 2'd2;
    endfunction

    // Phase that follows ph; wraps at the bit boundary.
    function automatic logic [1:0] phase_step(logic [1:0] ph, ovs_mode_e m);
        logic [1:0] nxt;
        nxt = ph + 2'd1;
        return (nxt == ovs_factor(m)) ? 2'd0 : nxt;
    endfunction

    // Phase at which the last tick of a frame occurs.
    function automatic logic [1:0] last_phase(ovs_mode_e m);
        return (m == OVS_3X) ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/uart_gt_sync.sv
module uart_gt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_s,
    output logic fall_o
);
    logic [STAGES-1:0] chain;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain  <= '1;
            prev_q <= 1'b1;
        end else begin
            chain  <= {chain[STAGES-2:0], line_i};
            prev_q <= chain[STAGES-1];
        end
    end

    assign line_s = chain[STAGES-1];
    assign fall_o = prev_q & ~line_s;

endmodule

// File: rtl/uart_gt_ticker.sv
module uart_gt_ticker #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_eff;

    assign div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
    assign tick    = run && (cnt == div_q - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            div_q <= DIV_W'(1);
        end else begin
            if (load) div_q <= div_eff;
            if (!run || tick) cnt <= '0;
            else              cnt <= cnt + DIV_W'(1);
        end
    end

    p_timer_held_r1: assert property (@(posedge clk) disable iff (rst)
        !run |-> (cnt == '0));

    p_divisor_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> $stable(div_q));

endmodule

// File: rtl/uart_gt_frame.sv
module uart_gt_frame
    import uart_gt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       line_s,
    input  logic       fall,
    input  logic       mode_i,
    input  logic       tick,
    output logic       start,
    output logic       busy,
    output rx_result_t res_o
);
    rx_state_e             state;
    ovs_mode_e             mode_q;
    logic [1:0]            ph;
    logic [IDX_W-1:0]      bi;
    logic [DATA_BITS-1:0]  shreg;
    logic                  ref_q;
    logic                  in_zone;
    logic                  gacc;
    logic                  stop_q;
    rx_result_t            res_q;

    logic [1:0]            ph_n;
    logic [IDX_W-1:0]      bi_n;
    logic                  samp, zend, fin, abort, gl_now, stop_now;

    assign busy  = (state == RX_BUSY);
    assign start = (state == RX_IDLE) && fall;

    assign ph_n     = phase_step(ph, mode_q);
    assign bi_n     = (ph_n == 2'd0) ? bi + IDX_W'(1) : bi;
    assign samp     = busy && tick && (ph_n == 2'd1);
    assign zend     = busy && tick && (mode_q == OVS_3X) && (ph_n == 2'd2);
    assign fin      = busy && tick && (bi_n == IDX_W'(STOP_IDX)) && (ph_n == last_phase(mode_q));
    assign abort    = samp && (bi_n == '0) && line_s;
    assign gl_now   = in_zone && (line_s != ref_q);
    assign stop_now = (mode_q == OVS_2X) ? line_s : stop_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            mode_q  <= OVS_2X;
            ph      <= '0;
            bi      <= '0;
            shreg   <= '0;
            ref_q   <= 1'b1;
            in_zone <= 1'b0;
            gacc    <= 1'b0;
            stop_q  <= 1'b1;
            res_q   <= '0;
        end else begin
            res_q.valid      <= 1'b0;
            res_q.frame_err  <= 1'b0;
            res_q.glitch_err <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (fall) begin
                        state   <= RX_BUSY;
                        mode_q  <= ovs_mode_e'(mode_i);
                        ph      <= '0;
                        bi      <= '0;
                        in_zone <= 1'b0;
                        gacc    <= 1'b0;
                    end
                end
                RX_BUSY: begin
                    if (gl_now) gacc <= 1'b1;
                    if (tick) begin
                        ph <= ph_n;
                        bi <= bi_n;
                    end
                    if (samp) begin
                        ref_q   <= line_s;
                        in_zone <= (mode_q == OVS_3X);
                        if (bi_n >= IDX_W'(1) && bi_n <= IDX_W'(DATA_BITS))
                            shreg <= {line_s, shreg[DATA_BITS-1:1]};
                        if (bi_n == IDX_W'(STOP_IDX))
                            stop_q <= line_s;
                    end
                    if (zend) in_zone <= 1'b0;
                    if (abort) begin
                        state   <= RX_IDLE;
                        in_zone <= 1'b0;
                    end else if (fin) begin
                        state            <= RX_IDLE;
                        in_zone          <= 1'b0;
                        res_q.valid      <= 1'b1;
                        res_q.data       <= shreg;
                        res_q.frame_err  <= ~stop_now;
                        res_q.glitch_err <= gacc | gl_now;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    assign res_o = res_q;

    p_one_cycle_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        res_q.valid |=> !res_q.valid);

    p_flags_ride_valid_r7: assert property (@(posedge clk) disable iff (rst)
        (res_q.frame_err || res_q.glitch_err) |-> res_q.valid);

    p_result_follows_tick_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(res_q.valid) |-> $past(tick));

    p_no_glitch_in_2x_r5: assert property (@(posedge clk) disable iff (rst)
        (res_q.valid && mode_q == OVS_2X) |-> !res_q.glitch_err);

    p_zone_only_3x_r5: assert property (@(posedge clk) disable iff (rst)
        in_zone |-> (busy && mode_q == OVS_3X));

    p_frame_begins_clean_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (ph == '0 && bi == '0));

endmodule

// File: rtl/uart_gt_rx.sv
module uart_gt_rx
    import uart_gt_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_i,
    input  logic                 mode_i,
    input  logic [DIV_W-1:0]     div_i,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 valid_o,
    output logic                 frame_err_o,
    output logic                 glitch_err_o
);
    logic       line_s, fall, tick, start, busy;
    rx_result_t res;

    uart_gt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .line_i (rx_i),
        .line_s (line_s),
        .fall_o (fall)
    );

    uart_gt_ticker #(.DIV_W(DIV_W)) u_ticker (
        .clk   (clk),
        .rst   (rst),
        .load  (start),
        .run   (busy),
        .div_i (div_i),
        .tick  (tick)
    );

    uart_gt_frame u_frame (
        .clk    (clk),
        .rst    (rst),
        .line_s (line_s),
        .fall   (fall),
        .mode_i (mode_i),
        .tick   (tick),
        .start  (start),
        .busy   (busy),
        .res_o  (res)
    );

    assign data_o       = res.data;
    assign valid_o      = res.valid;
    assign frame_err_o  = res.frame_err;
    assign glitch_err_o = res.glitch_err;

    p_idle_silent_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> !valid_o);

endmodule

// File: tb/test_uart_gt_rx.sv
module test_uart_gt_rx;

    typedef struct packed {
        logic        m;
        logic [15:0] d;
        logic [7:0]  data;
        logic        stopv;
        logic [1:0]  gk;    // 0 none, 1 stable-zone glitch, 2 transition glitch
        logic        chg;   // change mode/divisor mid-frame
        logic        ef;
        logic        eg;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'd4, 8'hA5, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 16'd1, 8'h3C, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0},
        '{1'b1, 16'd4, 8'h5A, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0},
        '{1'b1, 16'd3, 8'h81, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 16'd5, 8'h00, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0},
        '{1'b1, 16'd4, 8'hC3, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1},
        '{1'b1, 16'd4, 8'h96, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0},
        '{1'b0, 16'd4, 8'h6E, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0},
        '{1'b0, 16'd0, 8'hF0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0},
        '{1'b1, 16'd4, 8'h47, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0},
        '{1'b1, 16'd6, 8'hFF, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_i = 1'b1;
    logic        mode_i = 1'b0;
    logic [15:0] div_i = 16'd4;
    logic [7:0]  data_o;
    logic        valid_o, frame_err_o, glitch_err_o;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int vcnt = 0;
    int cap_cyc = 0;
    logic [7:0] cap_data = 8'h00;
    logic cap_f = 1'b0, cap_g = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (valid_o) begin
            vcnt     <= vcnt + 1;
            cap_cyc  <= cyc;
            cap_data <= data_o;
            cap_f    <= frame_err_o;
            cap_g    <= glitch_err_o;
        end
    end

    uart_gt_rx i_uart_gt_rx (
        .clk          (clk),
        .rst          (rst),
        .rx_i         (rx_i),
        .mode_i       (mode_i),
        .div_i        (div_i),
        .data_o       (data_o),
        .valid_o      (valid_o),
        .frame_err_o  (frame_err_o),
        .glitch_err_o (glitch_err_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send(input bit m, input int d, input logic [7:0] data,
                        input bit stopv, input int gk, input bit chg,
                        input bit keep_low, output int c0);
        int dd;
        int per;
        dd  = (d == 0) ? 1 : d;
        per = (m ? 3 : 2) * dd;
        for (int n = 0; n < 10 * per; n++) begin
            int  b;
            int  k;
            logic v;
            @(negedge clk);
            b = n / per;
            k = n % per;
            if (n == 0) begin
                mode_i = m;
                div_i  = 16'(d);
                c0     = cyc;
            end
            if (chg && n == 4) begin
                mode_i = ~m;
                div_i  = 16'd7;
            end
            v = (b == 0) ? 1'b0 : (b == 9) ? stopv : data[b-1];
            if (b == 3 && ((gk == 1 && k == dd + dd / 2) || (gk == 2 && k == 1)))
                v = ~v;
            rx_i = v;
        end
        @(negedge clk);
        rx_i = keep_low ? 1'b0 : 1'b1;
        repeat (2 * per + 10) @(negedge clk);
    endtask

    task automatic run_frame(input bit m, input int d, input logic [7:0] data,
                             input bit stopv, input int gk, input bit chg,
                             input bit ef, input bit eg, input bit keep_low);
        int v0;
        int c0;
        int dd;
        v0 = vcnt;
        dd = (d == 0) ? 1 : d;
        send(m, d, data, stopv, gk, chg, keep_low, c0);
        chk(vcnt == v0 + 1, "R7", "valid pulse count", vcnt - v0, 1);
        chk(cap_data == data, "R3", "data byte", cap_data, data);
        chk(cap_f == ef, "R6", "framing error", cap_f, ef);
        chk(cap_g == eg, "R5", "glitch error", cap_g, eg);
        chk(cap_cyc - c0 == 3 + (m ? 29 : 19) * dd, "R7", "latency",
            cap_cyc - c0, 3 + (m ? 29 : 19) * dd);
        if (chg) chk(cap_data == data, "R2", "mid-frame change ignored", cap_data, data);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v0;
        int c0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset state
        chk(valid_o == 1'b0, "R7", "reset valid", valid_o, 0);
        chk(data_o == 8'h00, "R7", "reset data", data_o, 0);
        chk(frame_err_o == 1'b0 && glitch_err_o == 1'b0, "R6", "reset flags",
            frame_err_o | glitch_err_o, 0);

        // R1: long idle line produces nothing
        v0 = vcnt;
        repeat (300) @(negedge clk);
        chk(vcnt == v0, "R1", "no pulse while idle", vcnt - v0, 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            run_frame(VECS[i].m, int'(VECS[i].d), VECS[i].data, VECS[i].stopv,
                      int'(VECS[i].gk), VECS[i].chg, VECS[i].ef, VECS[i].eg, 1'b0);
            mode_i = 1'b0;
            div_i  = 16'd4;
        end

        // R7: data holds after the pulse
        repeat (50) @(negedge clk);
        chk(data_o == VECS[NV-1].data, "R7", "data held", data_o, VECS[NV-1].data);

        // R4: short low pulse is dropped as noise, in both modes
        for (int m = 0; m < 2; m++) begin
            v0 = vcnt;
            @(negedge clk);
            mode_i = m[0];
            div_i  = 16'd4;
            rx_i   = 1'b0;
            repeat (2) @(negedge clk);
            rx_i = 1'b1;
            repeat (200) @(negedge clk);
            chk(vcnt == v0, "R4", "noise start dropped", vcnt - v0, 0);
            run_frame(m[0], 4, 8'h2D, 1'b1, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        end

        // R8: low stop bit followed by a held-low line
        run_frame(1'b0, 3, 8'h99, 1'b0, 0, 1'b0, 1'b1, 1'b0, 1'b1);
        v0 = vcnt;
        repeat (400) @(negedge clk);
        chk(vcnt == v0, "R8", "held-low line starts no frame", vcnt - v0, 0);
        rx_i = 1'b1;
        repeat (20) @(negedge clk);
        chk(vcnt == v0, "R8", "release starts no frame", vcnt - v0, 0);
        run_frame(1'b1, 2, 8'h7E, 1'b1, 0, 1'b0, 1'b0, 1'b0, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule